// File: doc/BRIEF.md
# Receive Programmable-Gain Automatic Gain Controller

This block chooses the gain setting of a receive programmable-gain amplifier so that the converter that follows it is neither driven into clipping nor left with a signal too small to resolve. It takes signed converter samples qualified by a valid strobe. It measures the largest sample magnitude seen over a window of a fixed number of valid samples. When each window ends, it moves the gain code by at most one step.

The gain ladder has nine settings, coded 0 to 8. Code 0 is the lowest gain at -18 dB, and every step up adds 6 dB. Each step therefore doubles the amplification and halves the largest input swing the converter can take. A window peak at or above an upper threshold near converter full scale lowers the gain by one code. A window peak below a lower threshold, set under half scale, raises the gain by one code. The two thresholds are more than a factor of two apart, so a single 6 dB step cannot push the peak from one side of the band straight across to the other, and the loop does not toggle between neighbouring codes. An enable input lets the surrounding receiver freeze the setting, for example while a frame is being demodulated.

Top module: `rx_pga_agc`

## Requirements
- R1: While reset (rst_n low) is sampled at a clock edge, the gain code becomes 0 and the gain in dB becomes -18.
- R2: The gain code never takes a value above 8. Further weak windows at code 8 leave it at 8.
- R3: gain_db always equals 6 × gain_code − 18 as a two's-complement value, ranging from −18 to +30.
- R4: A window holds exactly WIN_LEN samples that have sample_valid high. Samples with sample_valid low are neither counted nor considered for the peak.
- R5: If a window's peak magnitude is at or above HI_THR and enable is high, the gain code falls by one on the clock edge after the edge that captured the window's last sample. At code 0 it stays at 0.
- R6: If a window's peak magnitude is below LO_THR and enable is high, the gain code rises by one at that same point, stopping at 8.
- R7: A window peak at or above LO_THR and below HI_THR leaves the gain code unchanged.
- R8: The peak starts afresh with the first valid sample of each window, so a sample from an earlier window has no influence on a later decision.
- R9: If enable is low on the cycle where a completed window is evaluated, the gain code does not change, whatever the peak.
- R10: Sample magnitude is the absolute value of the two's-complement sample. The most negative code, −2^(SAMPLE_W−1), counts as magnitude 2^(SAMPLE_W−1).
- R11: The gain code changes by exactly one code at a time, and only on the cycle after a window completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Allows gain changes when high; freezes the code when low |
| sample | input | SAMPLE_W | Signed converter sample |
| sample_valid | input | 1 | Qualifies sample for the current cycle |
| gain_code | output | 4 | Selected amplifier code, 0 to 8 |
| gain_db | output | 7 | Signed gain in dB matching gain_code |

## Verification
The last valid sample of a window is registered into the window peak on its own clock edge. The gain code moves on the next edge, and gain_db follows combinationally from the code. Every result is therefore due two edges after the final sample is driven. The bench drives each sample at a falling edge and adds one idle cycle after each window. It compares code and dB at the falling edge that follows, using a bench model of the code that applies the thresholds arithmetically. A partial-window test samples the code again after WIN_LEN−1 valid samples plus idle cycles, to show that nothing is due before the window is full.

// File: rtl/rx_agc_pkg.sv
// Package: shared constants, the gain-code type and the code-to-dB mapping
// of the receive gain ladder. It assumes a fixed ladder of nine codes in
// equal 6 dB steps, starting at -18 dB.
package rx_agc_pkg;

    localparam int unsigned CODE_W    = 4;
    localparam int unsigned MAX_CODE  = 8;
    localparam int unsigned DB_W      = 7;
    localparam int          DB_AT_MIN = -18;
    localparam int          DB_STEP   = 6;

    typedef logic [CODE_W-1:0] gain_code_t;

    // Returns the signed dB value of a gain code.
    function automatic logic signed [DB_W-1:0] code_to_db(input gain_code_t c);
        int v;
        v = DB_AT_MIN + DB_STEP * int'(c);
        return v[DB_W-1:0];
    endfunction

endpackage

// File: rtl/rx_agc_peak.sv
// Module: windowed peak-magnitude tracker.
// It counts valid samples into windows of WIN_LEN. It keeps the largest
// absolute value seen in the current window and restarts that value with
// the first sample of each window. When a window's last sample arrives, it
// presents the window peak and pulses win_done for one cycle, both
// registered. Assumes SAMPLE_W >= 2. Magnitude carries SAMPLE_W unsigned
// bits, enough to hold the most negative input.
module rx_agc_peak #(
    parameter int unsigned SAMPLE_W = 12,
    parameter int unsigned WIN_LEN  = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic                       sample_valid,
    output logic                       win_done,
    output logic        [SAMPLE_W-1:0] win_peak
);

    localparam int unsigned CNT_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;

    logic [SAMPLE_W-1:0] mag;
    logic [SAMPLE_W-1:0] run_peak_q;
    logic [SAMPLE_W-1:0] run_peak_nxt;
    logic                first_smp;
    logic                last_smp;

    // Absolute value of the two's-complement input sample.
    always_comb begin
        mag = sample[SAMPLE_W-1] ? (~sample + 1'b1) : sample;
    end

    generate
        if (WIN_LEN > 1) begin : g_counted
            localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIN_LEN - 1);
            logic [CNT_W-1:0] idx_q;

            // Position of the next valid sample inside its window.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    idx_q <= '0;
                end else if (sample_valid) begin
                    idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
                end
            end

            assign first_smp = (idx_q == '0);
            assign last_smp  = (idx_q == LAST_IDX);
        end else begin : g_single
            assign first_smp = 1'b1;
            assign last_smp  = 1'b1;
        end
    endgenerate

    // Running maximum: restarts on the first sample of each window.
    always_comb begin
        if (first_smp || (mag > run_peak_q)) begin
            run_peak_nxt = mag;
        end else begin
            run_peak_nxt = run_peak_q;
        end
    end

    // Holds the running maximum between valid samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_peak_q <= '0;
        end else if (sample_valid) begin
            run_peak_q <= run_peak_nxt;
        end
    end

    // Publishes the completed window peak with a one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_done <= 1'b0;
            win_peak <= '0;
        end else begin
            win_done <= sample_valid && last_smp;
            if (sample_valid && last_smp) begin
                win_peak <= run_peak_nxt;
            end
        end
    end

endmodule

// File: rtl/rx_agc_stepper.sv
// Module: gain-code decision register.
// On a completed window with enable high, it steps the code down by one when
// the peak is at or above HI_THR and up by one when it is below LO_THR,
// holding inside the ladder limits. Otherwise the code holds. Assumes
// LO_THR < HI_THR, both representable in MAG_W bits.
module rx_agc_stepper
    import rx_agc_pkg::*;
#(
    parameter int unsigned MAG_W  = 12,
    parameter int unsigned HI_THR = 1792,
    parameter int unsigned LO_THR = 768
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             win_done,
    input  logic [MAG_W-1:0] win_peak,
    output gain_code_t       gain_code
);

    localparam logic [MAG_W-1:0] HI_V   = MAG_W'(HI_THR);
    localparam logic [MAG_W-1:0] LO_V   = MAG_W'(LO_THR);
    localparam gain_code_t       TOP_CD = CODE_W'(MAX_CODE);

    gain_code_t code_q;
    gain_code_t code_nxt;
    logic       too_big;
    logic       too_small;

    // Threshold comparison of the finished window peak.
    always_comb begin
        too_big   = (win_peak >= HI_V);
        too_small = (win_peak < LO_V);
    end

    // Next code: one step at most, attenuation taking priority.
    always_comb begin
        code_nxt = code_q;
        if (win_done && enable) begin
            if (too_big) begin
                if (code_q != '0) code_nxt = code_q - 1'b1;
            end else if (too_small) begin
                if (code_q < TOP_CD) code_nxt = code_q + 1'b1;
            end
        end
    end

    // Gain code register; reset selects the lowest gain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            code_q <= code_nxt;
        end
    end

    assign gain_code = code_q;

endmodule

// File: rtl/rx_agc_dbmap.sv
// Module: converts the gain code to its signed dB value. Purely
// combinational; assumes a code within the ladder.
module rx_agc_dbmap
    import rx_agc_pkg::*;
(
    input  gain_code_t              gain_code,
    output logic signed [DB_W-1:0]  gain_db
);

    // Ladder lookup through the shared mapping function.
    always_comb begin
        gain_db = code_to_db(gain_code);
    end

endmodule

// File: rtl/rx_pga_agc.sv
// Module: receive PGA automatic gain controller (top).
// Chains the windowed peak tracker, the single-step gain decision and the
// dB mapping. Assumes sample is the signed converter output and that the
// amplifier applies a new code before the next window's samples matter.
module rx_pga_agc #(
    parameter int unsigned SAMPLE_W = 12,
    parameter int unsigned WIN_LEN  = 64,
    parameter int unsigned HI_THR   = 1792,
    parameter int unsigned LO_THR   = 768
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic                       sample_valid,
    output logic        [3:0]          gain_code,
    output logic signed [6:0]          gain_db
);

    logic                win_done;
    logic [SAMPLE_W-1:0] win_peak;

    rx_agc_peak #(
        .SAMPLE_W (SAMPLE_W),
        .WIN_LEN  (WIN_LEN)
    ) u_peak (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample       (sample),
        .sample_valid (sample_valid),
        .win_done     (win_done),
        .win_peak     (win_peak)
    );

    rx_agc_stepper #(
        .MAG_W  (SAMPLE_W),
        .HI_THR (HI_THR),
        .LO_THR (LO_THR)
    ) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .win_done  (win_done),
        .win_peak  (win_peak),
        .gain_code (gain_code)
    );

    rx_agc_dbmap u_db (
        .gain_code (gain_code),
        .gain_db   (gain_db)
    );

endmodule

// File: rtl/rx_pga_agc_chk.sv
// Module: property checker for rx_pga_agc, attached by bind below.
// Observes the top ports plus the window pulse and peak that pass between
// the tracker and the decision register.
module rx_pga_agc_chk #(
    parameter int unsigned SAMPLE_W = 12,
    parameter int unsigned HI_THR   = 1792,
    parameter int unsigned LO_THR   = 768
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       enable,
    input logic                       sample_valid,
    input logic        [3:0]          gain_code,
    input logic signed [6:0]          gain_db,
    input logic                       win_done,
    input logic        [SAMPLE_W-1:0] win_peak
);

    // R1
    reset_code_chk: assert property (@(posedge clk)
        !rst_n |=> (gain_code == 4'd0));

    // R2
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain_code <= 4'd8);

    // R3
    db_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(gain_code) == int'($past(gain_code)) + 1)
            |-> (int'(gain_db) == int'($past(gain_db)) + 6));

    // R4
    window_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> $past(sample_valid));

    // R5
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && enable && (int'(win_peak) >= int'(HI_THR)) && (gain_code != 4'd0))
            |=> (int'(gain_code) == int'($past(gain_code)) - 1));

    // R6
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && enable && (int'(win_peak) < int'(LO_THR)) && (gain_code != 4'd8))
            |=> (int'(gain_code) == int'($past(gain_code)) + 1));

    // R9
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(gain_code));

    // R11
    only_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_code != $past(gain_code)) |-> $past(win_done));

endmodule

bind rx_pga_agc rx_pga_agc_chk #(
    .SAMPLE_W (SAMPLE_W),
    .HI_THR   (HI_THR),
    .LO_THR   (LO_THR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .sample_valid (sample_valid),
    .gain_code    (gain_code),
    .gain_db      (gain_db),
    .win_done     (win_done),
    .win_peak     (win_peak)
);

// File: tb/rx_pga_agc_bench.sv
module rx_pga_agc_bench;

    localparam int W  = 8;
    localparam int WL = 4;
    localparam int HI = 112;
    localparam int LO = 48;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                enable;
    logic signed [W-1:0] sample;
    logic                sample_valid;
    logic        [3:0]   gain_code;
    logic signed [6:0]   gain_db;

    int checks   = 0;
    int errors   = 0;
    int exp_code = 0;

    always #10 clk = ~clk;

    rx_pga_agc #(
        .SAMPLE_W (W),
        .WIN_LEN  (WL),
        .HI_THR   (HI),
        .LO_THR   (LO)
    ) u_rx_pga_agc (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .sample       (sample),
        .sample_valid (sample_valid),
        .gain_code    (gain_code),
        .gain_db      (gain_db)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_out(input string req);
        check(req, int'(gain_code), exp_code);
        check("R3", int'($signed(gain_db)), 6 * exp_code - 18);
    endtask

    task automatic drive(input int v, input bit vld);
        @(negedge clk);
        sample       = v[W-1:0];
        sample_valid = vld;
    endtask

    // Reference decision from the requirements (R5, R6, R7, R9, R2).
    task automatic model(input int pk, input bit en);
        if (en) begin
            if (pk >= HI) begin
                if (exp_code > 0) exp_code--;
            end else if (pk < LO) begin
                if (exp_code < 8) exp_code++;
            end
        end
    endtask

    // One full window whose peak magnitude is pk at position pos; others pk/3.
    task automatic run_window(input int pk, input bit neg, input int pos,
                              input bit en, input bit junk, input string req);
        enable = en;
        for (int i = 0; i < WL; i++) begin
            if (junk) drive(-128, 1'b0);
            if (i == pos) drive(neg ? -pk : pk, 1'b1);
            else          drive(pk / 3, 1'b1);
        end
        drive(0, 1'b0);
        @(negedge clk);
        model(pk, en);
        check_out(req);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n        = 1'b0;
        enable       = 1'b0;
        sample       = '0;
        sample_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check_out("R1");
        rst_n = 1'b1;

        // R5 floor at code 0
        run_window(120, 1'b0, 0, 1'b1, 1'b0, "R5");
        // R10 most negative sample is full scale
        run_window(128, 1'b1, 2, 1'b1, 1'b0, "R10");
        // R6 climb, then R2 saturation at 8
        for (int k = 0; k < 8; k++) run_window(10, k[0], k % WL, 1'b1, 1'b0, "R6");
        run_window(0, 1'b0, 0, 1'b1, 1'b0, "R2");
        run_window(5, 1'b1, 3, 1'b1, 1'b0, "R2");
        // R9 frozen despite strong peak
        run_window(127, 1'b0, 1, 1'b0, 1'b0, "R9");
        run_window(-0, 1'b0, 1, 1'b0, 1'b0, "R9");
        // R5 step down, R7 hold
        run_window(120, 1'b1, 1, 1'b1, 1'b0, "R5");
        run_window(80, 1'b0, 2, 1'b1, 1'b0, "R7");
        run_window(HI - 1, 1'b0, 3, 1'b1, 1'b0, "R7");
        run_window(LO, 1'b1, 0, 1'b1, 1'b0, "R7");
        // R8 strong window then weak window: the old peak is forgotten
        run_window(127, 1'b0, 3, 1'b1, 1'b0, "R8");
        run_window(5, 1'b0, 0, 1'b1, 1'b0, "R8");
        // R4 invalid full-scale samples interleaved are ignored
        run_window(20, 1'b0, 1, 1'b1, 1'b1, "R4");
        // R4 window length: WL-1 valid samples leave the code alone
        enable = 1'b1;
        for (int i = 0; i < WL - 1; i++) drive(5, 1'b1);
        drive(0, 1'b0);
        drive(-128, 1'b0);
        drive(0, 1'b0);
        @(negedge clk);
        check_out("R4");
        drive(5, 1'b1);
        drive(0, 1'b0);
        @(negedge clk);
        model(5, 1'b1);
        check_out("R11");
        // Sweep every magnitude with alternating sign and position
        for (int p = 0; p <= 128; p++) begin
            run_window(p, (p % 2 == 1) || (p == 128), p % WL, 1'b1, 1'b0,
                       (p >= HI) ? "R5" : ((p < LO) ? "R6" : "R7"));
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule